// File: doc/BRIEF.md
# Serial Register-File Control Port

This block is the slave end of a four-wire serial control link. Through it a host microcontroller reads and writes a bank of 8-bit configuration registers. The host drives chip select, a serial clock and serial data in. The block returns serial data out together with an output-enable. The pad ring combines the two into a tri-state driver. The host may run the serial clock at any rate that is slow compared with the system clock, with no phase relation to it. The block brings all three host pins into the system clock domain through synchronizers and acts on the clock edges it detects there.

Every frame opens with a 7-bit device address and a read/write flag.

- **Write frame:** a pointer byte follows, then any number of data bytes.
- **Read frame:** the addressed register is returned right after the flag. To read, the host first sends a short write frame that carries only the pointer byte. It then opens a read frame.

Bit 7 of the pointer byte selects auto-increment, so a whole block of registers can move in one frame. The rest of the chip reads the bank through a combinational parallel port.

Top module: `spi_regfile_port`

## Requirements
- R1: A synchronous reset clears every register and the whole pointer byte to zero, and drops the output-enable.
- R2: A frame whose first 7 bits (MSB first) differ from binary 0010000 is ignored. No register changes, and the output-enable stays low until chip select rises.
- R3: In a write frame (bit 8 = 0), the next byte loads the pointer, and each further complete byte is written MSB first into the register at pointer bits 6:0. Input bits are taken on rising serial-clock edges.
- R4: When pointer bit 7 is 0, successive data bytes all go to the same register, and the last one stays.
- R5: When pointer bit 7 is 1, the index in bits 6:0 advances by one after each byte written or read, and wraps from 127 to 0.
- R6: The output-enable stays low for the whole of a write frame.
- R7: In a read frame (bit 8 = 1), the falling serial-clock edge after the flag bit raises the output-enable and drives the MSB of the register at the stored pointer. Each later falling edge drives the next bit.
- R8: With increment enabled, the bytes of a read frame come from consecutive registers with no gap. The pointer persists across frames, so a new read frame continues where the last one stopped.
- R9: Chip select rising at any point ends the frame. A partial byte is discarded without a write, and the output-enable drops.
- R10: The parallel port returns the register at `cfgRdAddr`. Indices at or above NUM_REGS read as zero, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spiCsN | input | 1 | Chip select from host, active low |
| spiSclk | input | 1 | Serial clock from host, idle low |
| spiSdi | input | 1 | Serial data from host |
| spiSdo | output | 1 | Serial data to host |
| spiSdoOe | output | 1 | Drive enable for spiSdo (low = high impedance) |
| cfgRdAddr | input | 7 | Parallel read index |
| cfgRdData | output | 8 | Parallel read data |

## Verification
Any host pin change reaches the datapath about four system cycles later: two synchronizer stages, an edge-detect register and the acting register. The bench holds each serial-clock phase for eight system cycles, so each result has settled before the opposite edge. Read bits and the output-enable are sampled at the end of the low phase, well after the launching falling edge. Register contents are checked on the parallel port some cycles after chip select rises. The output-enable is sampled on every bit of every frame, so a stray drive in a write frame, an ignored frame or an aborted frame is counted.

// File: rtl/spi_regfile_pkg.sv
package spi_regfile_pkg;

  typedef enum logic [2:0] {
    PH_ADDR   = 3'd0,
    PH_PTR    = 3'd1,
    PH_WDATA  = 3'd2,
    PH_RDATA  = 3'd3,
    PH_IGNORE = 3'd4
  } framePhase_t;

  typedef struct packed {
    logic shiftEn;   // rising serial edge: capture sdiBit
    logic sdiBit;    // synchronized data-in bit
    logic loadPtr;   // pointer byte complete
    logic writeReg;  // data byte complete, write bank
    logic advance;   // byte done in data phase: step pointer if enabled
    logic loadOut;   // load output shifter
    logic shiftOut;  // falling serial edge in read phase
    logic clearOut;  // chip select inactive
  } ctrlStrobes_t;

endpackage

// File: rtl/spi_regfile_ctrl.sv
module spi_regfile_ctrl
  import spi_regfile_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0010000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         spiCsN,
  input  logic         spiSclk,
  input  logic         spiSdi,
  input  logic [7:0]   inByte,
  output ctrlStrobes_t strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, sdiPipe;
  logic sclkPrev;
  logic csS, sclkS, sdiS;
  logic rise, fall, byteDone, addrHit;
  logic [2:0] bitCnt;
  framePhase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[LAST-1:0], spiCsN};
      sclkPipe <= {sclkPipe[LAST-1:0], spiSclk};
      sdiPipe  <= {sdiPipe[LAST-1:0], spiSdi};
      sclkPrev <= sclkPipe[LAST];
    end
  end

  assign csS   = csPipe[LAST];
  assign sclkS = sclkPipe[LAST];
  assign sdiS  = sdiPipe[LAST];

  assign rise     = !csS && sclkS && !sclkPrev;
  assign fall     = !csS && !sclkS && sclkPrev;
  assign byteDone = rise && (bitCnt == 3'd7);
  assign addrHit  = (inByte[7:1] == DEV_ADDR);

  always_ff @(posedge clk) begin
    if (rst || csS) begin
      bitCnt <= '0;
      phase  <= PH_ADDR;
    end else if (rise) begin
      bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        unique case (phase)
          PH_ADDR: phase <= !addrHit ? PH_IGNORE : (inByte[0] ? PH_RDATA : PH_PTR);
          PH_PTR:  phase <= PH_WDATA;
          default: phase <= phase;
        endcase
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.shiftEn  = rise;
    strb.sdiBit   = sdiS;
    strb.loadPtr  = byteDone && (phase == PH_PTR);
    strb.writeReg = byteDone && (phase == PH_WDATA);
    strb.advance  = byteDone && ((phase == PH_WDATA) || (phase == PH_RDATA));
    strb.loadOut  = byteDone && (((phase == PH_ADDR) && addrHit && inByte[0])
                                 || (phase == PH_RDATA));
    strb.shiftOut = fall && (phase == PH_RDATA);
    strb.clearOut = csS;
  end

  // An ignored frame must raise no bank or pointer strobe (R2)
  assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGNORE) |-> !(strb.writeReg || strb.loadPtr || strb.loadOut || strb.shiftOut));

  // Pointer load and register write are exclusive (R3)
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadPtr, strb.writeReg, strb.shiftOut}));

  // Frame end clears the bit count (R9)
  assert_bitcnt_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    csS |=> (bitCnt == 3'd0) && (phase == PH_ADDR));

endmodule

// File: rtl/spi_regfile_dp.sv
module spi_regfile_dp
  import spi_regfile_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strb,
  output logic [7:0]   inByte,
  output logic         spiSdo,
  output logic         spiSdoOe,
  input  logic [6:0]   cfgRdAddr,
  output logic [7:0]   cfgRdData
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [6:0] shiftIn;
  logic [7:0] ptr;
  logic [7:0] outShift;
  logic [7:0] regBank [NUM_REGS];
  logic [6:0] nextIdx, loadIdx;

  function automatic logic [7:0] readReg(input logic [6:0] idx);
    if (int'(idx) < NUM_REGS) return regBank[idx[IDX_W-1:0]];
    else return 8'h00;
  endfunction

  assign inByte  = {shiftIn, strb.sdiBit};
  assign nextIdx = ptr[7] ? (ptr[6:0] + 7'd1) : ptr[6:0];
  assign loadIdx = strb.advance ? nextIdx : ptr[6:0];

  always_ff @(posedge clk) begin
    if (rst) shiftIn <= '0;
    else if (strb.shiftEn) shiftIn <= inByte[6:0];
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (strb.loadPtr) ptr <= inByte;
    else if (strb.advance) ptr[6:0] <= nextIdx;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst) regBank[g] <= '0;
      else if (strb.writeReg && (ptr[6:0] == 7'(g))) regBank[g] <= inByte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outShift <= '0;
      spiSdo   <= 1'b0;
      spiSdoOe <= 1'b0;
    end else if (strb.clearOut) begin
      spiSdo   <= 1'b0;
      spiSdoOe <= 1'b0;
    end else if (strb.loadOut) begin
      outShift <= readReg(loadIdx);
    end else if (strb.shiftOut) begin
      spiSdo   <= outShift[7];
      outShift <= {outShift[6:0], 1'b0};
      spiSdoOe <= 1'b1;
    end
  end

  assign cfgRdData = readReg(cfgRdAddr);

  // Pointer holds unless loaded or stepped (R4)
  assert_ptr_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !(strb.loadPtr || strb.advance) |=> $stable(ptr));

  // Enabled increment steps the index by one, wrapping (R5)
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && !strb.loadPtr && ptr[7]) |=> (ptr[6:0] == $past(ptr[6:0]) + 7'd1));

  // Drive only turns on from a read-phase shift (R7)
  assert_oe_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(spiSdoOe) |-> $past(strb.shiftOut));

  // Frame end releases the line (R9)
  assert_oe_release_R9: assert property (@(posedge clk) disable iff (rst)
    strb.clearOut |=> !spiSdoOe);

endmodule

// File: rtl/spi_regfile_port.sv
module spi_regfile_port
  import spi_regfile_pkg::*;
#(
  parameter int         NUM_REGS    = 32,
  parameter logic [6:0] DEV_ADDR    = 7'b0010000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spiCsN,
  input  logic       spiSclk,
  input  logic       spiSdi,
  output logic       spiSdo,
  output logic       spiSdoOe,
  input  logic [6:0] cfgRdAddr,
  output logic [7:0] cfgRdData
);

  ctrlStrobes_t strb;
  logic [7:0]   inByte;

  spi_regfile_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .spiCsN (spiCsN),
    .spiSclk(spiSclk),
    .spiSdi (spiSdi),
    .inByte (inByte),
    .strb   (strb)
  );

  spi_regfile_dp #(
    .NUM_REGS(NUM_REGS)
  ) uDp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .inByte   (inByte),
    .spiSdo   (spiSdo),
    .spiSdoOe (spiSdoOe),
    .cfgRdAddr(cfgRdAddr),
    .cfgRdData(cfgRdData)
  );

endmodule

// File: tb/sim_spi_regfile_port.sv
`timescale 1ns/1ps
module sim_spi_regfile_port;

  localparam time HALF = 64ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spiCsN = 1'b1, spiSclk = 1'b0, spiSdi = 1'b0;
  logic spiSdo, spiSdoOe;
  logic [6:0] cfgRdAddr = '0;
  logic [7:0] cfgRdData;

  int vecCnt = 0;
  int missCnt = 0;
  int oeHigh = 0;
  logic [7:0] rx;

  always #4ns clk = ~clk;

  spi_regfile_port u0 (
    .clk(clk), .rst(rst), .spiCsN(spiCsN), .spiSclk(spiSclk), .spiSdi(spiSdi),
    .spiSdo(spiSdo), .spiSdoOe(spiSdoOe), .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regIs(input string req, input logic [6:0] idx, input logic [7:0] exp);
    cfgRdAddr = idx;
    #1ns;
    check(req, cfgRdData, exp);
  endtask

  task automatic csLow();
    oeHigh = 0;
    spiCsN = 1'b0;
    #HALF;
  endtask

  task automatic csHigh();
    #HALF;
    spiCsN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // one bit: drive in low phase, sample output at its end, then pulse clock
  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      spiSdi = tx[i];
      #HALF;
      got[i] = spiSdo;
      if (spiSdoOe) oeHigh++;
      spiSclk = 1'b1;
      #HALF;
      spiSclk = 1'b0;
    end
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] got);
    xferBits(tx, 8, got);
  endtask

  task automatic setPtr(input logic [7:0] p);
    logic [7:0] d;
    csLow(); xferByte(8'h20, d); xferByte(p, d); csHigh();
  endtask

  task automatic tReset();
    regIs("R1 reg0", 7'd0, 8'h00);
    regIs("R1 reg5", 7'd5, 8'h00);
    check("R1 oe", spiSdoOe, 1'b0);
  endtask

  task automatic tWriteSingle();
    logic [7:0] d;
    csLow(); xferByte(8'h20, d); xferByte(8'h03, d); xferByte(8'hA5, d); csHigh();
    regIs("R3 reg3", 7'd3, 8'hA5);
    regIs("R3 reg4", 7'd4, 8'h00);
    check("R6 oe in write", oeHigh, 0);
  endtask

  task automatic tWriteFixed();
    logic [7:0] d;
    csLow(); xferByte(8'h20, d); xferByte(8'h05, d);
    xferByte(8'h11, d); xferByte(8'h22, d); xferByte(8'h33, d); csHigh();
    regIs("R4 reg5 last", 7'd5, 8'h33);
    regIs("R4 reg6 untouched", 7'd6, 8'h00);
    check("R6 oe in write", oeHigh, 0);
  endtask

  task automatic tWriteIncr();
    logic [7:0] d;
    csLow(); xferByte(8'h20, d); xferByte(8'h8A, d);
    xferByte(8'h01, d); xferByte(8'h02, d); xferByte(8'h03, d); xferByte(8'h04, d); csHigh();
    regIs("R5 reg10", 7'd10, 8'h01);
    regIs("R5 reg11", 7'd11, 8'h02);
    regIs("R5 reg12", 7'd12, 8'h03);
    regIs("R5 reg13", 7'd13, 8'h04);
  endtask

  task automatic tWrongAddr();
    logic [7:0] d;
    csLow(); xferByte(8'h22, d); xferByte(8'h03, d); xferByte(8'hFF, d); csHigh();
    regIs("R2 reg3 kept", 7'd3, 8'hA5);
    check("R2 oe write", oeHigh, 0);
    csLow(); xferByte(8'h23, d); xferByte(8'h00, d); xferByte(8'h00, d); csHigh();
    check("R2 oe read", oeHigh, 0);
  endtask

  task automatic tRead();
    setPtr(8'h03);
    csLow(); xferByte(8'h21, rx); xferByte(8'h00, rx); csHigh();
    check("R7 data", rx, 8'hA5);
    check("R7 oe bits", oeHigh, 8);
  endtask

  task automatic tReadIncr();
    logic [7:0] a, b, c;
    setPtr(8'h8A);
    csLow(); xferByte(8'h21, rx);
    xferByte(8'h00, a); xferByte(8'h00, b); xferByte(8'h00, c); csHigh();
    check("R8 byte0", a, 8'h01);
    check("R8 byte1", b, 8'h02);
    check("R8 byte2", c, 8'h03);
    csLow(); xferByte(8'h21, rx); xferByte(8'h00, a); csHigh();
    check("R8 pointer kept", a, 8'h04);
  endtask

  task automatic tWrapRange();
    logic [7:0] d;
    csLow(); xferByte(8'h20, d); xferByte(8'h9F, d);
    xferByte(8'h77, d); xferByte(8'h66, d); csHigh();
    regIs("R10 reg31", 7'd31, 8'h77);
    regIs("R10 idx32 zero", 7'd32, 8'h00);
    csLow(); xferByte(8'h20, d); xferByte(8'hFF, d);
    xferByte(8'h44, d); xferByte(8'h55, d); csHigh();
    regIs("R10 idx127 zero", 7'd127, 8'h00);
    regIs("R5 wrap reg0", 7'd0, 8'h55);
  endtask

  task automatic tAbort();
    logic [7:0] d;
    csLow(); xferByte(8'h20, d); xferByte(8'h07, d); xferByte(8'h12, d);
    xferBits(8'hF0, 4, d); csHigh();
    regIs("R9 partial dropped", 7'd7, 8'h12);
    setPtr(8'h07);
    csLow(); xferByte(8'h21, d); xferBits(8'h00, 4, d);
    #HALF; spiCsN = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 oe released", spiSdoOe, 1'b0);
    check("R9 oe was on", oeHigh, 4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    tReset();
    tWriteSingle();
    tWriteFixed();
    tWriteIncr();
    tWrongAddr();
    tRead();
    tReadIncr();
    tWrapRange();
    tAbort();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    missCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule